// File: doc/BRIEF.md
# Bit-Stream Elastic Store with Fill-Level Frequency Error

This block buffers a serial tributary between two unrelated clocks. Bits arrive on a recovered input clock and are written into a 1024-entry, one-bit-wide circular store. They leave on a locally synthesized clock. The block continuously reports how full the store is as a 10-bit unsigned code in the read clock domain.

The fill code is centred at mid-scale (512). It is meant to drive an external digitally controlled oscillator that generates the read clock. A code above 512 means bits are piling up, so the oscillator must speed up. A code below 512 means the store is draining, so it must slow down. In the intended application the oscillator maps 256 to 50 ppm below a 1.544 MHz centre and 768 to 50 ppm above it, at about 0.3016 Hz per code. The store therefore serves as the phase/frequency detector of a digital locked loop.

Pointers cross between the domains in Gray code. If the fill level comes within a guard margin of empty or full, the read pointer is moved back to half a store's distance behind the write pointer, and a one-cycle slip pulse is raised.

Top module: `es_phase_store`

## Requirements
- R1: While reset is asserted, the error code is 512 and the slip flag is low.
- R2: When input bits arrive faster than they are read, the error code rises by one for every extra bit written, apart from a lag of at most five codes from pointer synchronisation.
- R3: When input bits arrive slower than they are read, the error code falls by one for every extra bit read, within the same five-code lag.
- R4: Outside slips, the read pointer advances by one on every read clock. The bit on the data output, one read clock after read number n (counted from 1 after reset), is the bit written at write number n-512.
- R5: When the observed fill reaches the low guard (4 entries or fewer), slip pulses high for one read clock. The read pointer is recentred, and the next error code lies between 512 and 516.
- R6: When the observed fill reaches the high guard (1019 or more), slip pulses high for one read clock. The read pointer is recentred, and the next error code lies between 512 and 516.
- R7: The error code always stays strictly between the low guard (4) and the high guard (1019).
- R8: In a closed loop with an oscillator whose rate grows with the code, the error code settles within two codes of the integer code whose rate matches the input. This holds for codes 768, 256 and others in between.
- R9: When the matching code lies halfway between two integers (716.5), the error code keeps switching between 716 and 717. It stays within 715 to 718 and never stays on one value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n_i | input | 1 | Asynchronous active-low reset for both domains |
| wclk_i | input | 1 | Recovered input bit clock (write side) |
| din_i | input | 1 | Input bit, sampled on wclk_i |
| rclk_i | input | 1 | Synthesized bit clock (read side) |
| dout_o | output | 1 | Output bit, registered on rclk_i |
| err_o | output | 10 | Fill-level error code, mid-scale 512, read domain |
| slip_o | output | 1 | One-cycle pulse on a recentring slip, read domain |

## Verification
The store is first run at equal clock rates with random data. This shows that the data path delay is exactly half the store and that the code holds near mid-scale. Open-loop runs with the read clock 10% slow and 10% fast separate the bit-for-bit rise and fall of the code and drive the store into both slip directions. Closed-loop runs with a behavioural oscillator use integer targets (768, 256 and random codes) to show locking. A half-integer target shows that the code dithers between the two bracketing values rather than freezing.

// File: rtl/es_pkg.sv
package es_pkg;

    localparam int ES_AW          = 10;
    localparam int ES_GUARD       = 4;
    localparam int ES_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SLIP_NONE = 2'd0,
        SLIP_LOW  = 2'd1,
        SLIP_HIGH = 2'd2
    } slip_kind_e;

endpackage

// File: rtl/es_gray_sync.sv
module es_gray_sync #(
    parameter int             W       = 10,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/es_wr_ctrl.sv
module es_wr_ctrl #(
    parameter int AW = es_pkg::ES_AW
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          din_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic          rd_bit_o,
    output logic [AW-1:0] wgray_o
);

    localparam int            DEPTH    = 1 << AW;
    localparam logic [AW-1:0] MID      = {1'b1, {(AW-1){1'b0}}};
    localparam logic [AW-1:0] MID_GRAY = MID ^ (MID >> 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] wgray;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic      mem_q [DEPTH];

    always_comb begin
        st_d       = st_q;
        st_d.wptr  = st_q.wptr + AW'(1);
        st_d.wgray = st_d.wptr ^ (st_d.wptr >> 1);
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wptr  <= MID;
            st_q.wgray <= MID_GRAY;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge wclk) begin
        mem_q[st_q.wptr] <= din_i;
    end

    assign rd_bit_o = mem_q[rd_addr_i];
    assign wgray_o  = st_q.wgray;

    // R2: the pointer handed across domains changes in at most one bit per write
    p_gray_step_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(st_q.wgray ^ $past(st_q.wgray)) <= 1);

    // R4: one entry written per write clock
    p_wptr_step_r4: assert property (@(posedge wclk) disable iff (!rst_n)
        $past(rst_n) |-> (st_q.wptr == $past(st_q.wptr) + AW'(1)));

endmodule

// File: rtl/es_rd_ctrl.sv
module es_rd_ctrl
    import es_pkg::*;
#(
    parameter int AW    = ES_AW,
    parameter int GUARD = ES_GUARD
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [AW-1:0] wgray_sync_i,
    input  logic          rd_bit_i,
    output logic [AW-1:0] rd_addr_o,
    output logic          dout_o,
    output logic [AW-1:0] err_o,
    output logic          slip_o
);

    localparam int            DEPTH  = 1 << AW;
    localparam logic [AW-1:0] MID    = {1'b1, {(AW-1){1'b0}}};
    localparam logic [AW-1:0] LO_LIM = AW'(GUARD);
    localparam logic [AW-1:0] HI_LIM = AW'(DEPTH - 1 - GUARD);

    typedef struct packed {
        logic [AW-1:0] rptr;
        logic [AW-1:0] err;
        logic          dout;
        logic          slip;
    } rd_state_t;

    rd_state_t     st_d, st_q;
    logic [AW-1:0] wbin;
    logic [AW-1:0] fill;
    slip_kind_e    kind;

    function automatic logic [AW-1:0] gray_to_bin(input logic [AW-1:0] g);
        logic [AW-1:0] b;
        b[AW-1] = g[AW-1];
        for (int i = AW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_comb begin
        wbin = gray_to_bin(wgray_sync_i);
        fill = wbin - st_q.rptr;
        if (fill <= LO_LIM) begin
            kind = SLIP_LOW;
        end else if (fill >= HI_LIM) begin
            kind = SLIP_HIGH;
        end else begin
            kind = SLIP_NONE;
        end

        st_d      = st_q;
        st_d.dout = rd_bit_i;
        if (kind == SLIP_NONE) begin
            st_d.rptr = st_q.rptr + AW'(1);
            st_d.err  = fill;
            st_d.slip = 1'b0;
        end else begin
            st_d.rptr = wbin - MID;
            st_d.err  = MID;
            st_d.slip = 1'b1;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rptr <= '0;
            st_q.err  <= MID;
            st_q.dout <= 1'b0;
            st_q.slip <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr_o = st_q.rptr;
    assign dout_o    = st_q.dout;
    assign err_o     = st_q.err;
    assign slip_o    = st_q.slip;

    // R7: code never reaches either guard
    p_err_bounds_r7: assert property (@(posedge rclk) disable iff (!rst_n)
        (st_q.err > LO_LIM) && (st_q.err < HI_LIM));

    // R5: after a recentre the freshly measured fill sits just above mid-scale
    p_recentre_r5: assert property (@(posedge rclk) disable iff (!rst_n)
        st_q.slip |=> (st_q.err >= MID) && (st_q.err <= MID + LO_LIM));

    // R6: a slip is a single-cycle pulse
    p_single_slip_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        st_q.slip |=> !st_q.slip);

    // R4: read pointer advances by one except on a recentre
    p_rptr_adv_r4: assert property (@(posedge rclk) disable iff (!rst_n)
        ($past(rst_n) && !st_q.slip) |-> (st_q.rptr == $past(st_q.rptr) + AW'(1)));

endmodule

// File: rtl/es_phase_store.sv
module es_phase_store
    import es_pkg::*;
#(
    parameter int AW          = ES_AW,
    parameter int GUARD       = ES_GUARD,
    parameter int SYNC_STAGES = ES_SYNC_STAGES
) (
    input  logic          rst_n_i,
    input  logic          wclk_i,
    input  logic          din_i,
    input  logic          rclk_i,
    output logic          dout_o,
    output logic [AW-1:0] err_o,
    output logic          slip_o
);

    localparam logic [AW-1:0] MID      = {1'b1, {(AW-1){1'b0}}};
    localparam logic [AW-1:0] MID_GRAY = MID ^ (MID >> 1);

    logic [AW-1:0] wgray;
    logic [AW-1:0] wgray_sync;
    logic [AW-1:0] rd_addr;
    logic          rd_bit;

    es_wr_ctrl #(
        .AW (AW)
    ) u_wr (
        .wclk      (wclk_i),
        .rst_n     (rst_n_i),
        .din_i     (din_i),
        .rd_addr_i (rd_addr),
        .rd_bit_o  (rd_bit),
        .wgray_o   (wgray)
    );

    es_gray_sync #(
        .W       (AW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (MID_GRAY)
    ) u_w2r (
        .clk   (rclk_i),
        .rst_n (rst_n_i),
        .d_i   (wgray),
        .q_o   (wgray_sync)
    );

    es_rd_ctrl #(
        .AW    (AW),
        .GUARD (GUARD)
    ) u_rd (
        .rclk         (rclk_i),
        .rst_n        (rst_n_i),
        .wgray_sync_i (wgray_sync),
        .rd_bit_i     (rd_bit),
        .rd_addr_o    (rd_addr),
        .dout_o       (dout_o),
        .err_o        (err_o),
        .slip_o       (slip_o)
    );

endmodule

// File: tb/es_phase_store_tb_top.sv
module es_phase_store_tb_top;

    logic       wclk  = 1'b0;
    logic       rclk  = 1'b0;
    logic       rst_n = 1'b0;
    logic       din   = 1'b0;
    logic       dout;
    logic [9:0] err;
    logic       slip;

    int     n_chk = 0;
    int     n_bad = 0;
    longint nw = 0;
    longint nr = 0;
    longint wd = 0;
    bit     wr_bits [8192];
    bit     data_chk  = 1'b0;
    bit     loop_en   = 1'b0;
    bit     finished  = 1'b0;
    real    open_ratio = 1.0;
    real    tgt        = 512.0;
    real    gain       = 1.0e-3;

    es_phase_store dut_i (
        .rst_n_i (rst_n),
        .wclk_i  (wclk),
        .din_i   (din),
        .rclk_i  (rclk),
        .dout_o  (dout),
        .err_o   (err),
        .slip_o  (slip)
    );

    always #5000 wclk = ~wclk;

    // behavioural oscillator: rate follows the error code when the loop is closed
    initial begin : osc
        real    acc;
        real    ratio;
        longint emitted;
        longint dly;
        acc     = 0.0;
        emitted = 0;
        #1300;
        forever begin
            ratio   = loop_en ? (1.0 + gain * (real'(int'(err)) - tgt)) : open_ratio;
            acc     = acc + 5000.0 / ratio;
            dly     = longint'(acc) - emitted;
            emitted = emitted + dly;
            #(dly);
            rclk = ~rclk;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
    end

    always @(negedge wclk) din = 1'($urandom);

    always @(posedge wclk) begin
        if (rst_n) begin
            wr_bits[int'(nw % 8192)] = din;
            nw = nw + 1;
        end
    end

    always @(posedge rclk) if (rst_n) nr = nr + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R4: data path delay of half the store
    always @(negedge rclk) begin
        if (data_chk && rst_n && nr >= 513) begin
            chk(dout == wr_bits[int'((nr - 513) % 8192)], "R4", "output bit",
                longint'(dout), longint'(wr_bits[int'((nr - 513) % 8192)]));
        end
    end

    always @(posedge wclk) begin
        wd = wd + 1;
        if (wd > 195000 && !finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog", "cycles", wd, 195000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge wclk);
        rst_n = 1'b0;
        repeat (3) @(negedge wclk);
        chk(err == 10'd512, "R1", "error in reset", longint'(err), 512);
        chk(slip == 1'b0, "R1", "slip in reset", longint'(slip), 0);
        nw = 0;
        nr = 0;
        #700;
        rst_n = 1'b1;
    endtask

    task automatic reads(input int n);
        repeat (n) @(negedge rclk);
    endtask

    task automatic watch(input int n, output int mn, output int mx, output int flips,
                         output bit saw716, output bit saw717);
        int prev;
        mn = 1023; mx = 0; flips = 0; saw716 = 0; saw717 = 0;
        prev = int'(err);
        for (int i = 0; i < n; i++) begin
            @(negedge rclk);
            if (int'(err) < mn) mn = int'(err);
            if (int'(err) > mx) mx = int'(err);
            if (int'(err) != prev) flips++;
            if (err == 10'd716) saw716 = 1;
            if (err == 10'd717) saw717 = 1;
            prev = int'(err);
        end
    endtask

    task automatic run_to_slip(input string req, input bit low_side);
        int  guard_cnt;
        int  extreme;
        bit  seen;
        seen      = 0;
        guard_cnt = 0;
        extreme   = 512;
        while (!seen && guard_cnt < 20000) begin
            @(negedge rclk);
            guard_cnt++;
            if (slip) seen = 1;
            else if (low_side ? (int'(err) < extreme) : (int'(err) > extreme)) extreme = int'(err);
        end
        chk(seen, req, "slip pulse seen", longint'(seen), 1);
        if (low_side) chk(extreme > 4, "R7", "lowest code", extreme, 5);
        else          chk(extreme < 1019, "R7", "highest code", extreme, 1018);
        @(negedge rclk);
        chk(slip == 1'b0, req, "slip width", longint'(slip), 0);
        chk(err >= 10'd512 && err <= 10'd516, req, "code after recentre", longint'(err), 512);
    endtask

    initial begin : main
        int     mn, mx, flips;
        bit     s6, s7;
        longint exp;
        int     rt;

        // equal rates, random data
        loop_en    = 0;
        open_ratio = 1.0;
        do_reset();
        data_chk = 1;
        while (nr < 3000) @(negedge rclk);
        data_chk = 0;
        chk(err >= 10'd506 && err <= 10'd513, "R2", "code at equal rates", longint'(err), 512);

        // read 10% slow: code climbs, then high-side slip
        open_ratio = 0.9;
        reads(2000);
        exp = 512 + nw - (nr - 1);
        chk((longint'(err) - exp) <= 5 && (exp - longint'(err)) <= 5, "R2",
            "rising code", longint'(err), exp);
        run_to_slip("R6", 1'b0);

        // read 10% fast: code falls, then low-side slip
        do_reset();
        open_ratio = 1.1;
        reads(2000);
        exp = 512 + nw - (nr - 1);
        chk((longint'(err) - exp) <= 5 && (exp - longint'(err)) <= 5, "R3",
            "falling code", longint'(err), exp);
        run_to_slip("R5", 1'b1);

        // closed loop, integer target above centre
        do_reset();
        tgt     = 768.0;
        loop_en = 1;
        reads(10000);
        watch(2000, mn, mx, flips, s6, s7);
        chk(mn >= 766, "R8", "lock 768 min", mn, 766);
        chk(mx <= 770, "R8", "lock 768 max", mx, 770);

        // half-code target: dithering between bracketing codes
        tgt = 716.5;
        reads(8000);
        watch(14000, mn, mx, flips, s6, s7);
        chk(mn >= 715, "R9", "dither min", mn, 715);
        chk(mx <= 718, "R9", "dither max", mx, 718);
        chk(s6, "R9", "code 716 seen", longint'(s6), 1);
        chk(s7, "R9", "code 717 seen", longint'(s7), 1);
        chk(flips >= 2, "R9", "code changes", flips, 2);

        // integer target below centre
        tgt = 256.0;
        reads(12000);
        watch(1500, mn, mx, flips, s6, s7);
        chk(mn >= 254, "R8", "lock 256 min", mn, 254);
        chk(mx <= 258, "R8", "lock 256 max", mx, 258);

        // random integer targets
        for (int k = 0; k < 3; k++) begin
            rt  = 300 + int'($urandom % 400);
            tgt = real'(rt);
            reads(9000);
            watch(1000, mn, mx, flips, s6, s7);
            chk(mn >= rt - 2 && mx <= rt + 2, "R8", "random target lock", mn, rt);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule